// File: doc/BRIEF.md
# Dual-Mode PAM2/PAM4 Symbol Decision Decoder

This block sits behind the three data comparators of a serial-link receiver. The comparators are sampled once per symbol and are modelled here as three digital bits: an upper comparator, a centre comparator at zero, and a lower comparator. The block turns those bits into recovered data in one of three modes. In four-level mode it decodes a 2-bit Gray-coded symbol. In plain two-level mode it takes the centre comparator as the bit. In two-level mode with a loop-unrolled one-tap decision-feedback equalizer, the outer comparators are placed at the two speculative levels (+α above and −α below zero). The previous decision then selects which of the two gives the current bit.

Both outer comparator results are registered before the previous decision is applied, so the feedback loop is only a 2:1 select in front of a flop. A mode change flushes the pipeline, clears the previous decision, and blanks the output for a fixed number of symbols. This gives the analog front end time to move its thresholds.

Top module: `pam_dual_decoder`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `dec_vld_o` and `prev_bit_o` are 0.
- R2: With `mode_i`=2'b00 (plain two-level), an accepted symbol yields `dec_msb_o` equal to `cmp_mid_i`.
- R3: With `mode_i`=2'b01 (speculative one-tap DFE), an accepted symbol yields `dec_msb_o` = `cmp_hi_i` when `prev_bit_o` is 1 and `cmp_lo_i` when it is 0.
- R4: With `mode_i`=2'b10 or 2'b11 (four-level), `dec_msb_o` = `cmp_mid_i`. `dec_lsb_o` is the inverse of `cmp_hi_i` when `cmp_mid_i` is 1, and equals `cmp_lo_i` when `cmp_mid_i` is 0. The levels from top to bottom therefore decode as {msb,lsb} = 10, 11, 01, 00.
- R5: A symbol presented with `sym_vld_i` high at clock edge k and accepted is reported with `dec_vld_o` high after edge k+1. `dec_vld_o` is high only in that case.
- R6: `prev_bit_o` takes the new `dec_msb_o` each time `dec_vld_o` is raised. It is cleared to 0 by a mode change and is otherwise held.
- R7: At an edge where `mode_i` differs from the mode seen at the previous edge, any pending symbol is dropped. `dec_vld_o` and `prev_bit_o` go to 0, the strobe in that cycle is discarded, and the next FLUSH_SYMS (default 2) strobes are also discarded.
- R8: In plain two-level mode the outer comparator inputs have no effect on `dec_msb_o`.
- R9: In both two-level modes `dec_lsb_o` is 0 whenever `dec_vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 plain two-level, 01 two-level speculative DFE, 1x four-level |
| sym_vld_i | input | 1 | Comparator bits hold a new symbol this cycle |
| cmp_hi_i | input | 1 | Upper comparator (upper threshold or +α) |
| cmp_mid_i | input | 1 | Centre comparator at zero |
| cmp_lo_i | input | 1 | Lower comparator (lower threshold or −α) |
| dec_msb_o | output | 1 | Decided bit (two-level) or symbol MSB (four-level) |
| dec_lsb_o | output | 1 | Symbol LSB in four-level mode, 0 otherwise |
| dec_vld_o | output | 1 | Decision outputs carry a new symbol |
| prev_bit_o | output | 1 | Registered previous decision used as DFE select |

## Verification
The hardest situation to reach is a mode change that lands while a symbol is still in flight, combined with strobes arriving during the blanking window. Back-to-back DFE symbols must also follow the flush, so that the cleared previous decision selects the lower comparator first. The stimulus switches modes at random points of a dense random strobe stream. It also uses directed sequences that change mode right after a strobe and then feed consecutive DFE symbols whose correct outcome depends on the feedback chain.

// File: rtl/pam_dual_decoder.sv
module pam_dual_decoder #(
  parameter int FLUSH_SYMS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       sym_vld_i,
  input  logic       cmp_hi_i,
  input  logic       cmp_mid_i,
  input  logic       cmp_lo_i,
  output logic       dec_msb_o,
  output logic       dec_lsb_o,
  output logic       dec_vld_o,
  output logic       prev_bit_o
);
  localparam int CW = $clog2(FLUSH_SYMS + 1);
  localparam logic [1:0] M_PAM2 = 2'b00;
  localparam logic [1:0] M_DFE  = 2'b01;

  logic [1:0]    mode_q;
  logic [CW-1:0] blank_q;
  logic          cap_v, hi_q, mid_q, lo_q;
  logic          nxt_msb, nxt_lsb;

  wire chg  = (mode_i != mode_q);
  wire take = sym_vld_i && !chg && (blank_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_PAM2;
      blank_q <= '0;
      cap_v   <= 1'b0;
      hi_q    <= 1'b0;
      mid_q   <= 1'b0;
      lo_q    <= 1'b0;
    end else begin
      mode_q <= mode_i;
      cap_v  <= take;
      if (chg)
        blank_q <= CW'(FLUSH_SYMS);
      else if (sym_vld_i && blank_q != '0)
        blank_q <= blank_q - 1'b1;
      if (take) begin
        hi_q  <= cmp_hi_i;
        mid_q <= cmp_mid_i;
        lo_q  <= cmp_lo_i;
      end
    end
  end

  always_comb begin
    unique case (mode_q)
      M_PAM2: begin nxt_msb = mid_q; nxt_lsb = 1'b0; end
      M_DFE:  begin nxt_msb = prev_bit_o ? hi_q : lo_q; nxt_lsb = 1'b0; end
      default: begin nxt_msb = mid_q; nxt_lsb = mid_q ? ~hi_q : lo_q; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld_o  <= 1'b0;
      dec_msb_o  <= 1'b0;
      dec_lsb_o  <= 1'b0;
      prev_bit_o <= 1'b0;
    end else if (chg) begin
      dec_vld_o  <= 1'b0;
      prev_bit_o <= 1'b0;
    end else begin
      dec_vld_o <= cap_v;
      if (cap_v) begin
        dec_msb_o  <= nxt_msb;
        dec_lsb_o  <= nxt_lsb;
        prev_bit_o <= nxt_msb;
      end
    end
  end
endmodule

module pam_dual_decoder_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_i,
  input logic [1:0]    mode_q,
  input logic [CW-1:0] blank_q,
  input logic          cap_v,
  input logic          dec_lsb_o,
  input logic          dec_vld_o,
  input logic          prev_bit_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!dec_vld_o && !prev_bit_o)); // R1
  AST_VLD_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) dec_vld_o |-> $past(cap_v)); // R5
  AST_PREV_HELD: assert property (@(posedge clk) disable iff (!rst_n) !dec_vld_o |-> ($stable(prev_bit_o) || !prev_bit_o)); // R6
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (mode_i != mode_q) |=> (!dec_vld_o && !prev_bit_o)); // R7
  AST_BLANK_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (blank_q != '0) |=> !cap_v); // R7
  AST_LSB_ZERO_PAM2: assert property (@(posedge clk) disable iff (!rst_n) (dec_vld_o && !mode_q[1]) |-> !dec_lsb_o); // R9
endmodule

bind pam_dual_decoder pam_dual_decoder_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_q(mode_q), .blank_q(blank_q),
  .cap_v(cap_v), .dec_lsb_o(dec_lsb_o), .dec_vld_o(dec_vld_o), .prev_bit_o(prev_bit_o)
);

// File: tb/pam_dual_decoder_test.sv
`timescale 1ns/1ps
module pam_dual_decoder_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic vld = 1'b0, hi = 1'b0, mid = 1'b0, lo = 1'b0;
  logic msb_o, lsb_o, vld_o, prev_o;
  int   n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pam_dual_decoder uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .sym_vld_i(vld),
    .cmp_hi_i(hi), .cmp_mid_i(mid), .cmp_lo_i(lo),
    .dec_msb_o(msb_o), .dec_lsb_o(lsb_o), .dec_vld_o(vld_o), .prev_bit_o(prev_o)
  );

  logic [1:0] m_mode = 2'b00;
  int         m_blank = 0;
  logic       p_v = 1'b0, p_h, p_m, p_l;
  logic       m_prev = 1'b0;

  function automatic logic [1:0] ref_dec(logic [1:0] md, logic pv, logic h, logic m, logic l);
    if (md == 2'b00) return {m, 1'b0};
    if (md == 2'b01) return {(pv ? h : l), 1'b0};
    return {m, (m ? ~h : l)};
  endfunction

  function automatic string mtag(logic [1:0] md);
    if (md == 2'b00) return "R2 R8";
    if (md == 2'b01) return "R3";
    return "R4";
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic [1:0] md, logic v, logic h, logic m, logic l);
    logic       chg, e_vld;
    logic [1:0] e_dec;
    @(negedge clk);
    mode = md; vld = v; hi = h; mid = m; lo = l;
    chg = (md != m_mode);
    e_vld = 1'b0;
    e_dec = 2'b00;
    if (chg) begin
      m_prev = 1'b0;
    end else if (p_v) begin
      e_vld = 1'b1;
      e_dec = ref_dec(m_mode, m_prev, p_h, p_m, p_l);
      m_prev = e_dec[1];
    end
    if (chg) begin
      p_v = 1'b0; m_blank = 2; m_mode = md;
    end else if (v && m_blank > 0) begin
      m_blank--; p_v = 1'b0;
    end else if (v) begin
      p_v = 1'b1; p_h = h; p_m = m; p_l = l;
    end else begin
      p_v = 1'b0;
    end
    @(posedge clk); #1;
    chk(chg ? "R7 vld" : "R5 vld", {1'b0, vld_o}, {1'b0, e_vld});
    chk(chg ? "R7 prev" : "R6 prev", {1'b0, prev_o}, {1'b0, m_prev});
    if (e_vld && vld_o) begin
      chk(mtag(m_mode), {msb_o, 1'b0}, {e_dec[1], 1'b0});
      chk(m_mode[1] ? "R4 lsb" : "R9 lsb", {1'b0, lsb_o}, {1'b0, e_dec[0]});
    end
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 vld", {1'b0, vld_o}, 2'b00);
    chk("R1 prev", {1'b0, prev_o}, 2'b00);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 vld after release", {1'b0, vld_o}, 2'b00);

    // R2/R8: plain mode, outer comparators toggled against centre
    step(2'b00, 1, 1, 0, 1);
    step(2'b00, 1, 0, 1, 0);
    step(2'b00, 1, 1, 1, 1);
    step(2'b00, 0, 0, 0, 0);
    // R7: switch to four-level, strobes blanked
    step(2'b10, 1, 1, 1, 1);
    step(2'b10, 1, 1, 1, 1);
    step(2'b10, 1, 1, 1, 1);
    // R4: four levels top to bottom
    step(2'b10, 1, 1, 1, 1);
    step(2'b10, 1, 0, 1, 1);
    step(2'b10, 1, 0, 0, 1);
    step(2'b10, 1, 0, 0, 0);
    step(2'b10, 0, 0, 0, 0);
    // R3: DFE chain, first symbol after flush selects lower comparator
    step(2'b01, 1, 0, 0, 0);
    step(2'b01, 1, 0, 0, 0);
    step(2'b01, 0, 0, 0, 0);
    step(2'b01, 1, 0, 0, 1);
    step(2'b01, 1, 0, 1, 0);
    step(2'b01, 1, 1, 0, 0);
    step(2'b01, 1, 0, 1, 1);
    step(2'b01, 0, 1, 1, 1);
    step(2'b11, 0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [1:0] md;
      md = ($urandom_range(0, 39) == 0) ? 2'($urandom_range(0, 3)) : mode;
      step(md, ($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    step(mode, 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule